// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block models the device end of a three-wire serial EEPROM holding 64 words of 16 bits in flip-flops. A host raises the chip select and clocks in a command on the serial data input. Leading zeros are skipped until a start bit of 1 arrives. Then come a 2-bit opcode and a 6-bit address, and, for the two write forms, 16 data bits. The block reads a word, writes one word, erases one word, erases the whole array or fills the whole array with one value. It also sets and clears a write-enable latch that guards every command that changes memory.

A change to memory runs as a self-timed cycle. The cycle starts when the chip select drops and lasts a fixed number of system clocks. While it runs, the serial output shows busy (low) whenever the chip select is high, and it shows ready (high) once the cycle ends. The serial pins are synchronised into a free-running system clock domain, and all edge detection is done there. The serial output is high-impedance while the chip select is low; this is modelled by an enable output.

Top module: `uw_eeprom`

## Requirements
- R1: After reset the write-enable latch is disabled and every word reads as 16'hFFFF.
- R2: The data input is sampled on rising serial clock edges, and zeros before the first 1 are skipped. With opcode 10 (READ), the output drives 0 after the last address bit, and then drives the 16 data bits MSB first, one new bit after each rising serial clock.
- R3: Opcode 01 (WRITE) followed by 16 data bits stores exactly the data value, whatever the word held before. The word is erased and then programmed, so old bits never combine with the new value.
- R4: A write programs only if the chip select falls after the last data bit and before the next rising serial clock. If the chip select falls early, or an extra rising clock arrives first, memory is unchanged and no cycle starts.
- R5: Opcode 11 (ERASE) sets the addressed word to 16'hFFFF and leaves other words unchanged.
- R6: Opcode 00 uses address bits [5:4] as a sub-command: 11 enables writes and 00 disables them. Address bits [3:0] are ignored.
- R7: Sub-command 10 (erase all) sets every word to 16'hFFFF.
- R8: Sub-command 01 (write all), followed by 16 data bits, stores the data value in every word.
- R9: While the latch is disabled, WRITE, ERASE, erase-all and write-all start no cycle: the output reports ready at once and memory is unchanged.
- R10: A cycle begins on the chip select falling edge and lasts CYCLE_CLKS system clocks. With the chip select high, the output is 0 while busy and 1 when ready. Start bits are ignored while busy.
- R11: The output enable is low whenever the chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock |
| din | input | 1 | Serial data input |
| dout | output | 1 | Serial data output or ready/busy status |
| dout_en | output | 1 | Output drive enable (low means high-impedance) |

## Verification
The hardest situations to reach are a command that arrives while a program cycle is still running, and a program attempt that narrowly misses the chip-select window. For the first, the bench raises the chip select during the cycle and clocks in a full READ header aimed at a word holding 0000. It then keeps clocking after the cycle has ended. Because the command must have been ignored, every output bit must show ready (1) and never that word's zeros. For the second, the bench places one extra rising clock after the last data bit in one case, and drops the chip select one bit early in another. It then confirms that no busy phase appears and that the word still reads erased.

// File: rtl/uw_pkg.sv
package uw_pkg;
  typedef enum logic [2:0] {PG_NONE, PG_WRITE, PG_ERASE, PG_ERAL, PG_WRAL} prog_e;
  typedef enum logic [2:0] {ST_IDLE, ST_HDR, ST_RDOUT, ST_DATA, ST_ARMW, ST_ARME, ST_DONE} st_e;
  typedef enum logic [2:0] {DC_READ, DC_WRITE, DC_ERASE, DC_ERAL, DC_WRAL, DC_EWEN, DC_EWDS} dec_e;

  // opcode plus the two top address bits select the command
  function automatic dec_e decode_cmd(input logic [1:0] opc, input logic [1:0] ext);
    case (opc)
      2'b10: return DC_READ;
      2'b01: return DC_WRITE;
      2'b11: return DC_ERASE;
      default: begin
        case (ext)
          2'b11:   return DC_EWEN;
          2'b00:   return DC_EWDS;
          2'b10:   return DC_ERAL;
          default: return DC_WRAL;
        endcase
      end
    endcase
  endfunction
endpackage

// File: rtl/uw_sync_edge.sv
module uw_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs,
  input  logic din,
  output logic c_rise,
  output logic cs_lvl,
  output logic cs_fall,
  output logic din_lvl
);
  logic [2:0] raw_v;
  logic [2:0] lvl_v;
  logic [1:0] prev_q;

  assign raw_v = {din, cs, sclk};

  for (genvar i = 0; i < 3; i++) begin : g_sync
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-2:0], raw_v[i]};
    end
    assign lvl_v[i] = sh[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_v[1:0];
  end

  assign c_rise  = lvl_v[0] & ~prev_q[0];
  assign cs_fall = ~lvl_v[1] & prev_q[1];
  assign cs_lvl  = lvl_v[1];
  assign din_lvl = lvl_v[2];
endmodule

// File: rtl/uw_cmd.sv
module uw_cmd
  import uw_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          c_rise,
  input  logic          cs_lvl,
  input  logic          cs_fall,
  input  logic          din_lvl,
  input  logic          busy,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output prog_e         op_o,
  output logic          launch,
  output logic          wel_set,
  output logic          wel_clr,
  output logic          read_phase,
  output logic          rd_bit
);
  localparam int HDR_W   = 2 + AW;
  localparam int CNT_MAX = (HDR_W > DW + 1) ? HDR_W : DW + 1;
  localparam int CW      = $clog2(CNT_MAX + 1);

  st_e             st_q;
  logic [CW-1:0]   cnt_q;
  logic [HDR_W-1:0] hdr_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   data_q;
  prog_e           op_q;
  logic            launch_q, wel_set_q, wel_clr_q;

  logic [HDR_W-1:0] hdr_full;
  logic [DW-1:0]    data_full;
  dec_e             dec;

  // bit shown on the output at read position idx (0 is the dummy)
  function automatic logic word_bit(input logic [DW-1:0] w, input logic [CW-1:0] idx);
    logic [DW-1:0] t;
    if (idx == '0 || idx > CW'(DW)) return 1'b0;
    t = w >> (DW - int'(idx));
    return t[0];
  endfunction

  assign hdr_full  = {hdr_q[HDR_W-2:0], din_lvl};
  assign data_full = {data_q[DW-2:0], din_lvl};
  assign dec       = decode_cmd(hdr_full[HDR_W-1 -: 2], hdr_full[AW-1 -: 2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      hdr_q     <= '0;
      addr_q    <= '0;
      data_q    <= '0;
      op_q      <= PG_NONE;
      launch_q  <= 1'b0;
      wel_set_q <= 1'b0;
      wel_clr_q <= 1'b0;
    end else begin
      launch_q  <= 1'b0;
      wel_set_q <= 1'b0;
      wel_clr_q <= 1'b0;
      if (cs_fall) begin
        if (st_q == ST_ARMW || st_q == ST_ARME) launch_q <= 1'b1;
        st_q <= ST_IDLE;
      end else if (!cs_lvl) begin
        st_q <= ST_IDLE;
      end else if (c_rise) begin
        case (st_q)
          ST_IDLE: begin
            if (din_lvl && !busy) begin
              st_q  <= ST_HDR;
              cnt_q <= '0;
            end
          end
          ST_HDR: begin
            hdr_q <= hdr_full;
            if (cnt_q == CW'(HDR_W - 1)) begin
              addr_q <= hdr_full[AW-1:0];
              cnt_q  <= '0;
              case (dec)
                DC_READ:  st_q <= ST_RDOUT;
                DC_WRITE: begin op_q <= PG_WRITE; st_q <= ST_DATA; end
                DC_ERASE: begin op_q <= PG_ERASE; st_q <= ST_ARME; end
                DC_ERAL:  begin op_q <= PG_ERAL;  st_q <= ST_ARME; end
                DC_WRAL:  begin op_q <= PG_WRAL;  st_q <= ST_DATA; end
                DC_EWEN:  begin wel_set_q <= 1'b1; st_q <= ST_DONE; end
                default:  begin wel_clr_q <= 1'b1; st_q <= ST_DONE; end
              endcase
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_RDOUT: begin
            if (cnt_q <= CW'(DW)) cnt_q <= cnt_q + 1'b1;
          end
          ST_DATA: begin
            data_q <= data_full;
            if (cnt_q == CW'(DW - 1)) st_q <= ST_ARMW;
            else                      cnt_q <= cnt_q + 1'b1;
          end
          ST_ARMW: st_q <= ST_DONE;  // window missed
          default: ;
        endcase
      end
    end
  end

  assign addr_o     = addr_q;
  assign data_o     = data_q;
  assign op_o       = op_q;
  assign launch     = launch_q;
  assign wel_set    = wel_set_q;
  assign wel_clr    = wel_clr_q;
  assign read_phase = (st_q == ST_RDOUT);
  assign rd_bit     = read_phase & word_bit(rdata, cnt_q);
endmodule

// File: rtl/uw_store.sv
module uw_store
  import uw_pkg::*;
#(
  parameter int AW         = 6,
  parameter int DW         = 16,
  parameter int CYCLE_CLKS = 200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  prog_e         launch_op,
  input  logic [AW-1:0] launch_addr,
  input  logic [DW-1:0] launch_data,
  input  logic          wel_set,
  input  logic          wel_clr,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rdata,
  output logic          busy,
  output logic          wel,
  output logic          cycle_start,
  output logic          cycle_done
);
  localparam int DEPTH = 1 << AW;
  localparam int TW    = $clog2(CYCLE_CLKS + 1);

  logic [TW-1:0]              tmr_q;
  prog_e                      op_q;
  logic [AW-1:0]              addr_q;
  logic [DW-1:0]              data_q;
  logic                       wel_q;
  logic [DEPTH-1:0][DW-1:0]   words;

  // value of one word when a cycle commits
  function automatic logic [DW-1:0] next_word(input prog_e op, input logic hit,
                                              input logic [DW-1:0] d, input logic [DW-1:0] old);
    case (op)
      PG_WRITE: return hit ? d : old;
      PG_ERASE: return hit ? {DW{1'b1}} : old;
      PG_ERAL:  return {DW{1'b1}};
      PG_WRAL:  return d;
      default:  return old;
    endcase
  endfunction

  assign busy        = (tmr_q != '0);
  assign cycle_start = launch & wel_q & ~busy;
  assign cycle_done  = (tmr_q == TW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q  <= '0;
      op_q   <= PG_NONE;
      addr_q <= '0;
      data_q <= '0;
    end else if (cycle_start) begin
      tmr_q  <= TW'(CYCLE_CLKS);
      op_q   <= launch_op;
      addr_q <= launch_addr;
      data_q <= launch_data;
    end else if (busy) begin
      tmr_q <= tmr_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wel_q <= 1'b0;
    else if (wel_set) wel_q <= 1'b1;
    else if (wel_clr) wel_q <= 1'b0;
  end

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q <= {DW{1'b1}};
      else if (cycle_done) q <= next_word(op_q, addr_q == AW'(w), data_q, q);
    end
    assign words[w] = q;
  end

  assign rdata = words[rd_addr];
  assign wel   = wel_q;
endmodule

// File: rtl/uw_eeprom.sv
module uw_eeprom
  import uw_pkg::*;
#(
  parameter int AW          = 6,
  parameter int DW          = 16,
  parameter int CYCLE_CLKS  = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sclk,
  input  logic din,
  output logic dout,
  output logic dout_en
);
  logic          c_rise, cs_lvl, cs_fall, din_lvl;
  logic          busy, wel, cycle_start, cycle_done;
  logic          launch, wel_set, wel_clr, read_phase, rd_bit;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  prog_e         op;

  uw_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs(cs), .din(din),
    .c_rise(c_rise), .cs_lvl(cs_lvl), .cs_fall(cs_fall), .din_lvl(din_lvl)
  );

  uw_cmd #(.AW(AW), .DW(DW)) u_cmd (
    .clk(clk), .rst_n(rst_n), .c_rise(c_rise), .cs_lvl(cs_lvl), .cs_fall(cs_fall),
    .din_lvl(din_lvl), .busy(busy), .rdata(rdata), .addr_o(addr), .data_o(wdata),
    .op_o(op), .launch(launch), .wel_set(wel_set), .wel_clr(wel_clr),
    .read_phase(read_phase), .rd_bit(rd_bit)
  );

  uw_store #(.AW(AW), .DW(DW), .CYCLE_CLKS(CYCLE_CLKS)) u_store (
    .clk(clk), .rst_n(rst_n), .launch(launch), .launch_op(op), .launch_addr(addr),
    .launch_data(wdata), .wel_set(wel_set), .wel_clr(wel_clr), .rd_addr(addr),
    .rdata(rdata), .busy(busy), .wel(wel), .cycle_start(cycle_start),
    .cycle_done(cycle_done)
  );

  assign dout    = read_phase ? rd_bit : ~busy;
  assign dout_en = cs_lvl;
endmodule

// File: rtl/uw_eeprom_chk.sv
module uw_eeprom_chk #(
  parameter int CYCLE_CLKS = 200
) (
  input logic clk,
  input logic rst_n,
  input logic cs,
  input logic dout,
  input logic dout_en,
  input logic busy,
  input logic cs_fall,
  input logic wel
);
  int unsigned bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bcnt <= 0;
    else if (busy) bcnt <= bcnt + 1;
    else           bcnt <= 0;
  end

  AST_DESEL_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs && !$past(cs) && !$past(cs, 2)) |-> !dout_en);  // R11

  AST_LOCKED_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel));  // R9

  AST_START_ON_CS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_fall, 2));  // R4

  AST_CYCLE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (bcnt == CYCLE_CLKS));  // R10

  AST_BUSY_SHOWS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_en && busy) |-> !dout);  // R10
endmodule

bind uw_eeprom uw_eeprom_chk #(.CYCLE_CLKS(CYCLE_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .dout(dout), .dout_en(dout_en),
  .busy(busy), .cs_fall(cs_fall), .wel(wel)
);

// File: tb/sim_uw_eeprom.sv
module sim_uw_eeprom;
  localparam int CLK_P = 10;
  localparam int HALF  = 8 * CLK_P;
  localparam int CYC   = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sclk = 1'b0, din = 1'b0;
  logic dout, dout_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [15:0] mem_m [64];

  always #(CLK_P/2) clk = ~clk;

  uw_eeprom #(.CYCLE_CLKS(CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .din(din),
    .dout(dout), .dout_en(dout_en)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, output logic q);
    din = b;
    #(HALF);
    sclk = 1'b1;
    #(HALF);
    q = dout;
    sclk = 1'b0;
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    logic q;
    for (int i = n - 1; i >= 0; i--) send_bit(v[i], q);
  endtask

  task automatic cs_up();
    cs = 1'b1;
    #(HALF);
  endtask

  task automatic cs_down();
    cs = 1'b0;
    #(HALF);
  endtask

  task automatic do_read(input logic [5:0] a, input int lead0,
                         output logic [15:0] w, output logic dummy);
    logic q;
    cs_up();
    for (int i = 0; i < lead0; i++) send_bit(1'b0, q);
    send_bits(32'b110, 3);
    for (int i = 5; i >= 0; i--) send_bit(a[i], q);
    dummy = q;
    w = '0;
    for (int i = 0; i < 16; i++) begin
      send_bit(1'b0, q);
      w = {w[14:0], q};
    end
    cs_down();
  endtask

  // elapsed clocks from the chip select fall until ready, plus the early status sample
  task automatic wait_ready(output int el, output logic first_q);
    el = 0;
    repeat (5) begin #(CLK_P); el++; end
    cs = 1'b1;
    repeat (6) begin #(CLK_P); el++; end
    first_q = dout;
    while (dout !== 1'b1 && el < 2000) begin #(CLK_P); el++; end
    cs_down();
  endtask

  // mode 0 normal, 1 extra clock after data, 2 chip select drops one bit early
  task automatic do_write(input logic [5:0] a, input logic [15:0] d, input int mode,
                          output int el, output logic first_q);
    logic q;
    cs_up();
    send_bits(32'b101, 3);
    send_bits({26'd0, a}, 6);
    for (int i = 15; i >= 0; i--) begin
      if (!(mode == 2 && i == 0)) send_bit(d[i], q);
    end
    if (mode == 1) send_bit(1'b0, q);
    cs = 1'b0;
    wait_ready(el, first_q);
  endtask

  task automatic do_erase(input logic [5:0] a, output int el);
    logic fq;
    cs_up();
    send_bits(32'b111, 3);
    send_bits({26'd0, a}, 6);
    cs = 1'b0;
    wait_ready(el, fq);
  endtask

  // sub-command in address bits [5:4], bits [3:0] free
  task automatic do_ext(input logic [1:0] code, input logic [3:0] low,
                        input bit has_data, input logic [15:0] d, output int el);
    logic fq;
    cs_up();
    send_bits(32'b100, 3);
    send_bits({28'd0, code, 2'b00} | {28'd0, 2'b00, low[3:2]}, 4);
    send_bits({30'd0, low[1:0]}, 2);
    if (has_data) send_bits({16'd0, d}, 16);
    cs = 1'b0;
    if (code == 2'b10 || code == 2'b01) wait_ready(el, fq);
    else begin el = 0; #(HALF); end
  endtask

  task automatic read_check(input string tag, input logic [5:0] a);
    logic [15:0] w;
    logic dm;
    do_read(a, 0, w, dm);
    check(tag, {16'd0, w}, {16'd0, mem_m[a]});
  endtask

  initial begin
    #(CLK_P * 190000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    logic dm, fq;
    int el;
    int unsigned seed;
    logic [5:0] ra;
    logic [15:0] rd;
    seed = 32'd1234;
    void'($urandom(seed));
    for (int i = 0; i < 64; i++) mem_m[i] = 16'hFFFF;

    #(CLK_P * 4);
    rst_n = 1'b1;
    #(CLK_P * 4);
    check("R11 enable low after reset", {31'd0, dout_en}, 32'd0);
    read_check("R1 word 0 erased after reset", 6'd0);
    read_check("R1 word 63 erased after reset", 6'd63);

    do_write(6'd5, 16'h1234, 0, el, fq);
    check("R9 locked write: ready at once", {31'd0, fq}, 32'd1);
    check("R9 locked write: no cycle", {31'd0, el < CYC}, 32'd1);
    read_check("R9 locked write leaves word", 6'd5);
    do_erase(6'd5, el);
    check("R9 locked erase: no cycle", {31'd0, el < CYC}, 32'd1);

    do_ext(2'b11, 4'h0, 1'b0, 16'h0, el);
    do_write(6'd5, 16'hA5C3, 0, el, fq);
    mem_m[5] = 16'hA5C3;
    check("R10 busy shown low", {31'd0, fq}, 32'd0);
    check("R10 cycle length", {31'd0, (el >= CYC) && (el <= CYC + 12)}, 32'd1);
    do_read(6'd5, 3, w, dm);
    check("R2 dummy zero before data", {31'd0, dm}, 32'd0);
    check("R2 read with leading zeros", {16'd0, w}, {16'd0, mem_m[5]});

    do_write(6'd5, 16'h5A3C, 0, el, fq);
    mem_m[5] = 16'h5A3C;
    read_check("R3 overwrite ignores old bits", 6'd5);
    do_write(6'd9, 16'h0000, 0, el, fq);
    mem_m[9] = 16'h0000;
    read_check("R3 write all zeros", 6'd9);

    do_write(6'd6, 16'h0F0F, 1, el, fq);
    check("R4 extra clock: no cycle", {31'd0, fq}, 32'd1);
    read_check("R4 extra clock leaves word", 6'd6);
    do_write(6'd7, 16'h1111, 2, el, fq);
    check("R4 early fall: no cycle", {31'd0, el < CYC}, 32'd1);
    read_check("R4 early fall leaves word", 6'd7);

    // command during busy must be ignored
    begin
      logic q;
      cs_up();
      send_bits(32'b101, 3);
      send_bits(32'd8, 6);
      send_bits(32'hBEEF, 16);
      cs = 1'b0;
      mem_m[8] = 16'hBEEF;
      #(CLK_P * 5);
      cs = 1'b1;
      #(HALF);
      send_bits(32'b110, 3);
      send_bits(32'd9, 6);
      #(CLK_P * 80);
      for (int i = 0; i < 3; i++) begin
        send_bit(1'b0, q);
        check("R10 start ignored while busy", {31'd0, q}, 32'd1);
      end
      cs_down();
    end
    read_check("R3 write before busy probe", 6'd8);

    do_erase(6'd5, el);
    mem_m[5] = 16'hFFFF;
    read_check("R5 erase word", 6'd5);
    read_check("R5 neighbour kept", 6'd8);

    for (int n = 0; n < 14; n++) begin
      ra = 6'($urandom());
      rd = 16'($urandom());
      do_write(ra, rd, 0, el, fq);
      mem_m[ra] = rd;
      read_check("R3 random write", ra);
      if (n % 3 == 0) read_check("R3 random other word", 6'($urandom()));
    end

    do_ext(2'b00, 4'($urandom()), 1'b0, 16'h0, el);
    do_erase(6'd8, el);
    check("R6 disable: erase has no cycle", {31'd0, el < CYC}, 32'd1);
    read_check("R6 disable keeps word", 6'd8);
    do_ext(2'b11, 4'hA, 1'b0, 16'h0, el);
    do_erase(6'd8, el);
    mem_m[8] = 16'hFFFF;
    read_check("R6 enable with free bits", 6'd8);

    do_ext(2'b01, 4'h5, 1'b1, 16'h3C96, el);
    check("R8 write all cycle length", {31'd0, (el >= CYC) && (el <= CYC + 12)}, 32'd1);
    for (int i = 0; i < 64; i++) mem_m[i] = 16'h3C96;
    read_check("R8 write all word 0", 6'd0);
    read_check("R8 write all word 63", 6'd63);
    for (int i = 0; i < 3; i++) read_check("R8 write all random word", 6'($urandom()));

    do_ext(2'b10, 4'h3, 1'b0, 16'h0, el);
    for (int i = 0; i < 64; i++) mem_m[i] = 16'hFFFF;
    read_check("R7 erase all word 0", 6'd0);
    read_check("R7 erase all word 63", 6'd63);
    read_check("R7 erase all random word", 6'($urandom()));
    check("R11 enable low at end", {31'd0, dout_en}, 32'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule